// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when a DRAM row must be refreshed and takes the memory bus away from the host to do it. A free-running interval timer marks refresh due points. A row counter steps through every row address in turn. An arbiter weighs pending refresh work against host accesses and grants the bus to one side at a time. A multiplexer puts either the counter row or the host row on the row address output.

There are two scheduling modes. In distributed mode one refresh is owed every `RETAIN_CLKS / ROWS` clocks, and each one is slipped in between host accesses. In burst mode a due point every `BURST_GAP` clocks starts a run that refreshes all rows back to back. The host does not get the bus again until the run ends. Two cycle styles are offered. In the row-address style the counter row is driven on the address bus. In the internal-counter style (CAS before RAS) the address bus is left undriven and the memory uses its own row counter. The strobe sequencer that runs each cycle is outside the block. It answers each request with a one-cycle completion.

Arbiter states:
- `ARB_IDLE`: nobody owns the bus.
- `ARB_HOST`: a host access is running.
- `ARB_REF_ONE`: a single distributed refresh is running.
- `ARB_REF_BURST`: a full burst run is in progress.

Arbiter transitions:
- IDLE→HOST: the host requests, and no refresh is both pending and starved.
- IDLE→REF_ONE or IDLE→REF_BURST: a refresh is pending, and either the host is not requesting or the refresh is starved.
- HOST→IDLE: on the host completion.
- REF_ONE→IDLE: on the cycle completion.
- REF_BURST→IDLE: on the completion of the last row of the run.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held, `host_gnt`, `ref_req` and `pass_done` are 0. The first refresh after reset uses row 0.
- R2: In distributed mode with no host traffic, successive refresh cycles begin exactly `RETAIN_CLKS/ROWS` clocks apart (8 by default). Each cycle refreshes one row.
- R3: The row counter advances by one on each completed refresh and wraps from `ROWS-1` to 0. `pass_done` is high for exactly one cycle, in the cycle after the completion of row `ROWS-1`.
- R4: In burst mode a run refreshes all `ROWS` rows, in order, under one continuous `ref_req`. `host_gnt` stays 0 for the whole run even when the host is requesting. The host is granted in the cycle after the run ends.
- R5: In burst mode with no host traffic, successive runs begin exactly `BURST_GAP` clocks apart (48 by default).
- R6: With `cbr_style`=0, `row_out` carries the counter row and `row_drive`=1 during a refresh. Outside a refresh, `row_out` equals `host_row` and `row_drive`=1.
- R7: With `cbr_style`=1, a refresh shows `ref_cbr`=1 and `row_drive`=0. The internal row counter still advances in the same order.
- R8: A granted host access is never cut short. `host_gnt` holds until `host_done`, and `ref_req` and `host_gnt` are never high together.
- R9: A host request that meets a refresh pending for fewer than `STARVE_LIM` cycles is granted first. The refresh follows once the access ends.
- R10: A refresh pending for at least `STARVE_LIM` cycles is served before a new host request, in the cycle after the arbiter goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_burst | input | 1 | 1: burst runs, 0: distributed single refreshes |
| cbr_style | input | 1 | 1: internal-counter refresh style, 0: row-address style |
| host_req | input | 1 | Host wants the bus |
| host_row | input | ROW_W | Host row address |
| host_done | input | 1 | One-cycle pulse: granted host access has finished |
| cyc_done | input | 1 | One-cycle pulse from the strobe sequencer: refresh cycle finished |
| host_gnt | output | 1 | Host owns the bus |
| ref_req | output | 1 | Refresh cycle request to the strobe sequencer |
| ref_cbr | output | 1 | Current refresh uses the internal-counter style |
| row_out | output | ROW_W | Multiplexed row address |
| row_drive | output | 1 | Row address bus is to be driven |
| pass_done | output | 1 | One-cycle pulse when the row counter wraps |

## Verification
Two functions meet in the same cycle: the interval timer raising a new refresh debt, and the arbiter settling a host request. The bench first learns the timer phase from a refresh start. It then raises a host request exactly in the cycle the next debt is taken, and expects the host to win (R9). In a second case the host holds the bus across a due point for longer than the starvation limit while keeping its request up, and the refresh is expected to take the bus immediately afterwards (R10).

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE      = 2'd0,
        ARB_HOST      = 2'd1,
        ARB_REF_ONE   = 2'd2,
        ARB_REF_BURST = 2'd3
    } arb_state_t;

endpackage

// File: rtl/rs_tick_gen.sv
module rs_tick_gen #(
    parameter int GAP_DIST  = 8,
    parameter int GAP_BURST = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_burst,
    output logic tick
);
    localparam int GAP_MAX = (GAP_DIST > GAP_BURST) ? GAP_DIST : GAP_BURST;
    localparam int CW      = $clog2(GAP_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // terminal count follows the active mode
    assign lim  = mode_burst ? CW'(GAP_BURST - 1) : CW'(GAP_DIST - 1);
    assign tick = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/rs_row_ctr.sv
module rs_row_ctr #(
    parameter int ROWS = 8,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [RW-1:0] row_q,
    output logic          wrap_p
);
    localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            wrap_p <= 1'b0;
        end else begin
            wrap_p <= adv && (row_q == LAST);
            if (adv) begin
                row_q <= (row_q == LAST) ? '0 : row_q + RW'(1);
            end
        end
    end
endmodule

// File: rtl/rs_row_mux.sv
module rs_row_mux #(
    parameter int RW = 3
) (
    input  logic          ref_req,
    input  logic          cbr_style,
    input  logic [RW-1:0] ctr_row,
    input  logic [RW-1:0] host_row,
    output logic [RW-1:0] row_out,
    output logic          row_drive,
    output logic          ref_cbr
);
    always_comb begin
        row_out   = ref_req ? ctr_row : host_row;
        ref_cbr   = ref_req && cbr_style;
        // internal-counter refresh leaves the address bus floating
        row_drive = !(ref_req && cbr_style);
    end
endmodule

// File: rtl/rs_arbiter.sv
module rs_arbiter
    import rs_pkg::*;
#(
    parameter int ROWS       = 8,
    parameter int STARVE_LIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_burst,
    input  logic tick,
    input  logic host_req,
    input  logic host_done,
    input  logic cyc_done,
    output logic host_gnt,
    output logic ref_req,
    output logic adv
);
    localparam int LW = $clog2(ROWS + 1);
    localparam int SW = $clog2(STARVE_LIM + 1);

    arb_state_t    st_q, st_n;
    logic [LW-1:0] debt_q;
    logic [LW-1:0] left_q;
    logic          burst_due_q;
    logic [SW-1:0] wait_q;
    logic          want_ref, starved, debt_inc, debt_dec, burst_end;

    assign want_ref  = mode_burst ? burst_due_q : (debt_q != '0);
    assign starved   = (wait_q >= SW'(STARVE_LIM));
    assign debt_inc  = tick && !mode_burst && (debt_q != LW'(ROWS));
    assign debt_dec  = (st_q == ARB_REF_ONE) && cyc_done;
    assign burst_end = (st_q == ARB_REF_BURST) && cyc_done && (left_q == LW'(1));

    // next state
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ARB_IDLE: begin
                if (host_req && !(want_ref && starved)) begin
                    st_n = ARB_HOST;
                end else if (want_ref) begin
                    st_n = mode_burst ? ARB_REF_BURST : ARB_REF_ONE;
                end
            end
            ARB_HOST: begin
                if (host_done) st_n = ARB_IDLE;
            end
            ARB_REF_ONE: begin
                if (cyc_done) st_n = ARB_IDLE;
            end
            ARB_REF_BURST: begin
                if (burst_end) st_n = ARB_IDLE;
            end
            default: st_n = ARB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ARB_IDLE;
        else        st_q <= st_n;
    end

    // outputs
    always_comb begin
        host_gnt = 1'b0;
        ref_req  = 1'b0;
        unique case (st_q)
            ARB_HOST:                   host_gnt = 1'b1;
            ARB_REF_ONE, ARB_REF_BURST: ref_req  = 1'b1;
            default: ;
        endcase
        adv = ref_req && cyc_done;
    end

    // refresh debt, burst run length and starvation age
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt_q      <= '0;
            left_q      <= '0;
            burst_due_q <= 1'b0;
            wait_q      <= '0;
        end else begin
            unique case ({debt_inc, debt_dec})
                2'b10:   debt_q <= debt_q + LW'(1);
                2'b01:   debt_q <= debt_q - LW'(1);
                default: debt_q <= debt_q;
            endcase

            burst_due_q <= (burst_due_q && !burst_end) || (tick && mode_burst);

            if (st_q == ARB_IDLE && st_n == ARB_REF_BURST) begin
                left_q <= LW'(ROWS);
            end else if (st_q == ARB_REF_BURST && cyc_done) begin
                left_q <= left_q - LW'(1);
            end

            if (st_q == ARB_REF_ONE || st_q == ARB_REF_BURST || !want_ref) begin
                wait_q <= '0;
            end else if (!starved) begin
                wait_q <= wait_q + SW'(1);
            end
        end
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int ROWS        = 8,
    parameter int RETAIN_CLKS = 64,
    parameter int BURST_GAP   = 48,
    parameter int STARVE_LIM  = 4,
    localparam int ROW_W      = $clog2(ROWS),
    localparam int DIST_GAP   = RETAIN_CLKS / ROWS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_burst,
    input  logic             cbr_style,
    input  logic             host_req,
    input  logic [ROW_W-1:0] host_row,
    input  logic             host_done,
    input  logic             cyc_done,
    output logic             host_gnt,
    output logic             ref_req,
    output logic             ref_cbr,
    output logic [ROW_W-1:0] row_out,
    output logic             row_drive,
    output logic             pass_done
);
    logic             tick;
    logic             adv;
    logic [ROW_W-1:0] row_q;

    rs_tick_gen #(
        .GAP_DIST  (DIST_GAP),
        .GAP_BURST (BURST_GAP)
    ) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_burst (mode_burst),
        .tick       (tick)
    );

    rs_arbiter #(
        .ROWS       (ROWS),
        .STARVE_LIM (STARVE_LIM)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_burst (mode_burst),
        .tick       (tick),
        .host_req   (host_req),
        .host_done  (host_done),
        .cyc_done   (cyc_done),
        .host_gnt   (host_gnt),
        .ref_req    (ref_req),
        .adv        (adv)
    );

    rs_row_ctr #(
        .ROWS (ROWS)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .row_q  (row_q),
        .wrap_p (pass_done)
    );

    rs_row_mux #(
        .RW (ROW_W)
    ) u_mux (
        .ref_req   (ref_req),
        .cbr_style (cbr_style),
        .ctr_row   (row_q),
        .host_row  (host_row),
        .row_out   (row_out),
        .row_drive (row_drive),
        .ref_cbr   (ref_cbr)
    );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int ROWS = 8,
    parameter int RW   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_burst,
    input logic          cbr_style,
    input logic          host_done,
    input logic          cyc_done,
    input logic          host_gnt,
    input logic          ref_req,
    input logic          ref_cbr,
    input logic          row_drive,
    input logic          pass_done,
    input logic [RW-1:0] host_row,
    input logic [RW-1:0] row_out,
    input logic [RW-1:0] row_q
);
    localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

    a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_gnt && ref_req));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && !host_done) |=> host_gnt);

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && cyc_done && row_q != LAST) |=> (row_q == $past(row_q) + RW'(1)));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && cyc_done && row_q == LAST) |=> (pass_done && row_q == '0));

    a_r7_cbr: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && cbr_style) |-> (ref_cbr && !row_drive));

    a_r6_host: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_req |-> (row_out == host_row && row_drive));

    a_r4_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_burst && $fell(ref_req)) |-> pass_done);
endmodule

bind refresh_sched refresh_sched_chk #(
    .ROWS (ROWS),
    .RW   (ROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_burst (mode_burst),
    .cbr_style  (cbr_style),
    .host_done  (host_done),
    .cyc_done   (cyc_done),
    .host_gnt   (host_gnt),
    .ref_req    (ref_req),
    .ref_cbr    (ref_cbr),
    .row_drive  (row_drive),
    .pass_done  (pass_done),
    .host_row   (host_row),
    .row_out    (row_out),
    .row_q      (row_q)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
    localparam int ROWS = 8;
    localparam int RW   = 3;

    // scenario: [0] burst, [1] cbr, [7:2] refreshes to observe, [13:8] expected gap
    localparam logic [13:0] SCEN [4] = '{
        {6'd8,  6'd10, 1'b0, 1'b0},
        {6'd8,  6'd10, 1'b1, 1'b0},
        {6'd48, 6'd16, 1'b0, 1'b1},
        {6'd48, 6'd16, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_burst = 1'b0;
    logic          cbr_style = 1'b0;
    logic          host_req = 1'b0;
    logic [RW-1:0] host_row = '0;
    logic          host_done = 1'b0;
    logic          cyc_done = 1'b0;
    logic          host_gnt, ref_req, ref_cbr, row_drive, pass_done;
    logic [RW-1:0] row_out;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int ref_count = 0, rise_n = 0, pass_n = 0, pass_hi = 0;
    int log_row [64];
    int log_drv [64];
    int log_cbr [64];
    int rise_t  [64];

    refresh_sched u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_burst (mode_burst),
        .cbr_style  (cbr_style),
        .host_req   (host_req),
        .host_row   (host_row),
        .host_done  (host_done),
        .cyc_done   (cyc_done),
        .host_gnt   (host_gnt),
        .ref_req    (ref_req),
        .ref_cbr    (ref_cbr),
        .row_out    (row_out),
        .row_drive  (row_drive),
        .pass_done  (pass_done)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // strobe sequencer model and monitor
    initial begin
        int  seq = 0;
        bit  ref_prev = 1'b0;
        bit  pass_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                cyc_done = 1'b0;
                seq = 0;
            end else if (cyc_done) begin
                cyc_done = 1'b0;
                seq = 0;
            end else if (ref_req) begin
                seq++;
                if (seq == 2) begin
                    cyc_done = 1'b1;
                    if (ref_count < 64) begin
                        log_row[ref_count] = int'(row_out);
                        log_drv[ref_count] = int'(row_drive);
                        log_cbr[ref_count] = int'(ref_cbr);
                    end
                    ref_count++;
                end
            end
            if (ref_req && !ref_prev && rise_n < 64) begin
                rise_t[rise_n] = cyc;
                rise_n++;
            end
            if (pass_done) pass_hi++;
            if (pass_done && !pass_prev) pass_n++;
            ref_prev  = ref_req;
            pass_prev = pass_done;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit burst, input bit cbr);
        @(negedge clk);
        rst_n = 1'b0;
        mode_burst = burst;
        cbr_style = cbr;
        host_req = 1'b0;
        host_done = 1'b0;
        @(posedge clk);
        ref_count = 0; rise_n = 0; pass_n = 0; pass_hi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_rise();
        bit prev = ref_req;
        forever begin
            @(negedge clk);
            if (ref_req && !prev) break;
            prev = ref_req;
        end
    endtask

    initial begin
        #4000000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!host_gnt && !ref_req && !pass_done, "R1 outputs in reset",
            int'({host_gnt, ref_req, pass_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!host_gnt && !ref_req && !pass_done, "R1 outputs after release",
            int'({host_gnt, ref_req, pass_done}), 0);

        // table walk: R2 R3 R4 R5 R6 R7
        foreach (SCEN[s]) begin
            bit burst;
            bit cbr;
            int nref, gap, bad;
            burst = SCEN[s][0];
            cbr   = SCEN[s][1];
            nref  = int'(SCEN[s][7:2]);
            gap   = int'(SCEN[s][13:8]);
            do_reset(burst, cbr);
            while (ref_count < nref) @(posedge clk);
            repeat (3) @(posedge clk);
            chk(log_row[0] == 0, "R1 first row", log_row[0], 0);
            bad = 0;
            for (int i = 0; i < nref; i++) begin
                if (log_row[i] != i % ROWS) bad++;
            end
            chk(bad == 0, "R3 row order", bad, 0);
            bad = 0;
            for (int i = 0; i < nref; i++) begin
                if (log_drv[i] != int'(!cbr) || log_cbr[i] != int'(cbr)) bad++;
            end
            chk(bad == 0, cbr ? "R7 internal-counter style" : "R6 row driven", bad, 0);
            chk(rise_t[1] - rise_t[0] == gap, burst ? "R5 burst spacing" : "R2 interval",
                rise_t[1] - rise_t[0], gap);
            chk(rise_n == (burst ? nref / ROWS : nref),
                burst ? "R4 one request per run" : "R2 one row per cycle",
                rise_n, burst ? nref / ROWS : nref);
            chk(pass_n == nref / ROWS && pass_hi == pass_n, "R3 wrap pulse",
                pass_hi, nref / ROWS);
        end

        // R9: host request in the cycle the debt is taken wins
        do_reset(1'b0, 1'b0);
        wait_rise();
        repeat (7) @(negedge clk);
        host_req = 1'b1;
        host_row = 3'd5;
        @(negedge clk);
        chk(host_gnt && !ref_req, "R9 host before young refresh",
            int'({host_gnt, ref_req}), 2);
        chk(row_out == 3'd5 && row_drive, "R6 host row on bus", int'(row_out), 5);
        host_done = 1'b1;
        host_req = 1'b0;
        @(negedge clk);
        host_done = 1'b0;
        @(negedge clk);
        chk(ref_req && !host_gnt, "R9 refresh follows", int'({host_gnt, ref_req}), 1);

        // R8 and R10: long access, then starved refresh takes the bus
        wait_rise();
        host_req = 1'b1;
        while (!host_gnt) @(negedge clk);
        begin
            int bad = 0;
            for (int i = 0; i < 12; i++) begin
                if (!host_gnt || ref_req) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R8 access not cut short", bad, 0);
        end
        host_done = 1'b1;
        @(negedge clk);
        host_done = 1'b0;
        @(negedge clk);
        chk(ref_req && !host_gnt, "R10 starved refresh first", int'({host_gnt, ref_req}), 1);
        while (!host_gnt) @(negedge clk);
        host_done = 1'b1;
        host_req = 1'b0;
        @(negedge clk);
        host_done = 1'b0;

        // R4: burst run holds off a waiting host
        do_reset(1'b1, 1'b0);
        wait_rise();
        host_req = 1'b1;
        host_row = 3'd2;
        begin
            int bad = 0;
            while (ref_req) begin
                if (host_gnt) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R4 host held off during run", bad, 0);
        end
        chk(ref_count == ROWS, "R4 rows in run", ref_count, ROWS);
        @(negedge clk);
        chk(host_gnt == 1'b1, "R4 host granted after run", int'(host_gnt), 1);
        chk(row_out == 3'd2 && row_drive, "R6 host row after run", int'(row_out), 2);
        host_done = 1'b1;
        host_req = 1'b0;
        @(negedge clk);
        host_done = 1'b0;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule